// File: doc/BRIEF.md
# Keyhole Flash Write Engine

This block is the indirect write front end for a NOR-style flash array. Software never writes the array directly. It loads a word-aligned target address and two 32-bit data halves into a small register file, then writes a command code. The engine then performs one 64-bit program operation on a simple macro port. Programming can only pull bits toward 0, so the array stores the AND of its old content and the presented word. Keeping that rule is up to software.

A write moves through four states: IDLE, LAUNCH, PROG and FINISH. Accepting a write command in IDLE takes the engine to LAUNCH. LAUNCH captures the keyhole contents and pulses the start strobe, then always moves to PROG. In PROG a down-counter runs for the programmed duration, and the move to FINISH happens when the counter reaches 1. FINISH waits for the macro's done input. On done, FINISH returns to IDLE, or goes back to LAUNCH if another write is queued.

The address and data registers stay locked for the first half of each write. After that, software may stage the next word and issue another command, which is held until the current write ends. If the queued write falls in the same 256-byte row (32 words), it takes the shorter continuation path at half the duration. Sticky complete, almost-complete and error flags report progress, and the almost-complete flag can drive an interrupt.

Top module: `kh_flash_wr`

## Requirements
- R1: After reset, every register reads 0 except the duration register, which reads DUR_RST (16). The start, program and interrupt outputs are low.
- R2: Register 0 keeps bits [18:3] of the written value. It reads back with bits [2:0] and [31:19] as 0, and the kept field is presented as the 16-bit word index on fl_addr.
- R3: A write presents {high half (register 2), low half (register 1)} on fl_data, pulses fl_start for one cycle in LAUNCH, then holds fl_prog high for L cycles. L equals the duration (register 6), or 1 when the duration is 0.
- R4: Writing code 4 to register 3 starts a write. Any other code starts nothing and sets error flag bit 4 of status register 4. Writing 1 to that bit clears it.
- R5: Busy (status bit 0) goes high in the cycle after the command is accepted and stays high through FINISH. With done held high it is low again L+2 cycles after the command edge.
- R6: Keyhole-closed (status bit 1) is high in LAUNCH, and in PROG while the remaining count exceeds L/2. Writes to registers 0 to 2 while it is high are ignored.
- R7: Command-complete (status bit 2) is set at the edge that leaves FINISH with done high. It stays set until 1 is written to it.
- R8: Almost-complete (status bit 3) is set one cycle after the remaining count equals ALM_CYC (4). It is write-1-to-clear. irq equals this flag ANDed with enable bit 0 of control register 5.
- R9: A write command given while busy is queued and launches at the edge that leaves FINISH. If it is in the same 32-word row as the write just done, fl_cont is 1 and L becomes the duration halved (at least 1). Otherwise fl_cont is 0 and the full duration is used.
- R10: A further write command given while one is already queued is dropped and sets the error flag.
- R11: FINISH holds, with busy high, for as long as fl_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| fl_done | input | 1 | Macro acknowledges the end of the program operation |
| fl_start | output | 1 | One-cycle program start strobe |
| fl_cont | output | 1 | Current operation uses the same-row continuation path |
| fl_prog | output | 1 | Program timing phase active |
| fl_addr | output | 16 | Target 64-bit word index |
| fl_data | output | 64 | Word to program |
| irq | output | 1 | Almost-complete interrupt |

## Verification
Take t as the number of edges after the one that accepts the command, with done held high. Then fl_start is due at t=0, fl_prog at t=1..L, busy is low and complete is set from t=L+2, and almost-complete is set from t=L-ALM_CYC+2. The bench drives inputs on falling edges and samples every output and status bit once per cycle, half a clock after each rising edge. It checks each sample against these formulas, computed for durations from 0 to 16. Queued writes are checked against the chained schedule: the second launch comes at t=L+2, and idle follows 2+L2 cycles later.

// File: rtl/kh_pkg.sv
package kh_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_PROG   = 2'd2,
        S_FINISH = 2'd3
    } kh_state_e;

    localparam logic [2:0] OFS_ADDR = 3'd0;
    localparam logic [2:0] OFS_DLO  = 3'd1;
    localparam logic [2:0] OFS_DHI  = 3'd2;
    localparam logic [2:0] OFS_CMD  = 3'd3;
    localparam logic [2:0] OFS_STAT = 3'd4;
    localparam logic [2:0] OFS_CTRL = 3'd5;
    localparam logic [2:0] OFS_DUR  = 3'd6;

    localparam logic [3:0] CMD_WRITE = 4'h4;

    localparam int ST_BUSY  = 0;
    localparam int ST_CLOSE = 1;
    localparam int ST_CMP   = 2;
    localparam int ST_ALM   = 3;
    localparam int ST_ERR   = 4;

endpackage

// File: rtl/kh_regs.sv
module kh_regs
    import kh_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int DUR_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        waddr,
    input  logic [31:0]       wdata,
    input  logic              lock,
    output logic [ADDR_W-1:0] kaddr,
    output logic [31:0]       klo,
    output logic [31:0]       khi,
    output logic              ien,
    output logic [CNT_W-1:0]  dur
);

    localparam int LSB = 3;
    localparam int MSB = LSB + ADDR_W - 1;

    // keyhole registers: frozen while the engine holds them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kaddr <= '0;
            klo   <= '0;
            khi   <= '0;
        end else if (we && !lock) begin
            case (waddr)
                OFS_ADDR: kaddr <= wdata[MSB:LSB];
                OFS_DLO:  klo   <= wdata;
                OFS_DHI:  khi   <= wdata;
                default:  ;
            endcase
        end
    end

    // configuration registers: always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien <= 1'b0;
            dur <= CNT_W'(DUR_RST);
        end else if (we) begin
            case (waddr)
                OFS_CTRL: ien <= wdata[0];
                OFS_DUR:  dur <= wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/kh_fsm.sv
module kh_fsm
    import kh_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int ROW_LG  = 5,
    parameter int ALM_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] kaddr,
    input  logic [63:0]       kdata,
    input  logic [CNT_W-1:0]  dur,
    input  logic              fl_done,
    output logic              fl_start,
    output logic              fl_cont,
    output logic              fl_prog,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [63:0]       fl_data,
    output logic              kh_closed,
    output logic              busy,
    output logic              fin,
    output logic              alm_hit,
    output logic              drop
);

    localparam logic [CNT_W-1:0] ALM_V = CNT_W'(ALM_CYC);

    kh_state_e        state, nstate;
    logic             pend;
    logic [CNT_W-1:0] cnt, half;
    logic             finish_go, launch_now, same_row;

    function automatic logic [CNT_W-1:0] len_of(input logic c, input logic [CNT_W-1:0] d);
        logic [CNT_W-1:0] l;
        l = c ? (d >> 1) : d;
        if (l == '0) l = CNT_W'(1);
        return l;
    endfunction

    assign finish_go  = (state == S_FINISH) && fl_done;
    assign launch_now = ((state == S_IDLE) && wr_cmd) || (finish_go && (pend || wr_cmd));
    assign same_row   = kaddr[ADDR_W-1:ROW_LG] == fl_addr[ADDR_W-1:ROW_LG];

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (wr_cmd) nstate = S_LAUNCH;
            S_LAUNCH: nstate = S_PROG;
            S_PROG:   if (cnt <= CNT_W'(1)) nstate = S_FINISH;
            S_FINISH: if (fl_done) nstate = (pend || wr_cmd) ? S_LAUNCH : S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // datapath: queue, latched word, program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            fl_addr <= '0;
            fl_data <= '0;
            fl_cont <= 1'b0;
            cnt     <= '0;
            half    <= '0;
        end else begin
            if (finish_go)
                pend <= pend && wr_cmd;
            else if (wr_cmd && (state != S_IDLE))
                pend <= 1'b1;
            if (launch_now) begin
                fl_addr <= kaddr;
                fl_data <= kdata;
                fl_cont <= (state == S_FINISH) && same_row;
            end
            if (state == S_LAUNCH) begin
                cnt  <= len_of(fl_cont, dur);
                half <= len_of(fl_cont, dur) >> 1;
            end else if (state == S_PROG && cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        fl_start  = 1'b0;
        fl_prog   = 1'b0;
        kh_closed = 1'b0;
        busy      = 1'b1;
        fin       = 1'b0;
        alm_hit   = 1'b0;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_LAUNCH: begin
                fl_start  = 1'b1;
                kh_closed = 1'b1;
            end
            S_PROG: begin
                fl_prog   = 1'b1;
                kh_closed = cnt > half;
                alm_hit   = cnt == ALM_V;
            end
            S_FINISH: fin = fl_done;
        endcase
        drop = wr_cmd && (state != S_IDLE) && pend && !finish_go;
    end

endmodule

// File: rtl/kh_status.sv
module kh_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_we,
    input  logic [2:0] clr_bits,
    input  logic       fin,
    input  logic       alm_hit,
    input  logic       bad,
    input  logic       ien,
    output logic       st_cmp,
    output logic       st_alm,
    output logic       st_err,
    output logic       irq
);

    // sticky flags; a new event in the clearing cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_cmp <= 1'b0;
            st_alm <= 1'b0;
            st_err <= 1'b0;
        end else begin
            st_cmp <= fin     || (st_cmp && !(clr_we && clr_bits[0]));
            st_alm <= alm_hit || (st_alm && !(clr_we && clr_bits[1]));
            st_err <= bad     || (st_err && !(clr_we && clr_bits[2]));
        end
    end

    assign irq = st_alm && ien;

endmodule

// File: rtl/kh_flash_wr.sv
module kh_flash_wr
    import kh_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int DUR_RST = 16,
    parameter int ROW_LG  = 5,
    parameter int ALM_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fl_done,
    output logic              fl_start,
    output logic              fl_cont,
    output logic              fl_prog,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [63:0]       fl_data,
    output logic              irq
);

    logic [ADDR_W-1:0] kaddr;
    logic [31:0]       klo, khi;
    logic              ien;
    logic [CNT_W-1:0]  dur;
    logic              kh_closed, busy, fin, alm_hit, drop;
    logic              st_cmp, st_alm, st_err;
    logic              cmd_we, wr_cmd, bad;
    logic [4:0]        stat;

    assign cmd_we = reg_we && (reg_addr == OFS_CMD);
    assign wr_cmd = cmd_we && (reg_wdata[3:0] == CMD_WRITE);
    assign bad    = (cmd_we && (reg_wdata[3:0] != CMD_WRITE)) || drop;

    kh_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUR_RST(DUR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
        .lock(kh_closed), .kaddr(kaddr), .klo(klo), .khi(khi), .ien(ien), .dur(dur)
    );

    kh_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ROW_LG(ROW_LG), .ALM_CYC(ALM_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .kaddr(kaddr), .kdata({khi, klo}),
        .dur(dur), .fl_done(fl_done), .fl_start(fl_start), .fl_cont(fl_cont),
        .fl_prog(fl_prog), .fl_addr(fl_addr), .fl_data(fl_data), .kh_closed(kh_closed),
        .busy(busy), .fin(fin), .alm_hit(alm_hit), .drop(drop)
    );

    kh_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_we(reg_we && (reg_addr == OFS_STAT)), .clr_bits(reg_wdata[4:2]),
        .fin(fin), .alm_hit(alm_hit), .bad(bad), .ien(ien),
        .st_cmp(st_cmp), .st_alm(st_alm), .st_err(st_err), .irq(irq)
    );

    always_comb begin
        stat           = '0;
        stat[ST_BUSY]  = busy;
        stat[ST_CLOSE] = kh_closed;
        stat[ST_CMP]   = st_cmp;
        stat[ST_ALM]   = st_alm;
        stat[ST_ERR]   = st_err;
    end

    always_comb begin
        case (reg_addr)
            OFS_ADDR: reg_rdata = 32'({kaddr, 3'b000});
            OFS_DLO:  reg_rdata = klo;
            OFS_DHI:  reg_rdata = khi;
            OFS_STAT: reg_rdata = 32'(stat);
            OFS_CTRL: reg_rdata = 32'(ien);
            OFS_DUR:  reg_rdata = 32'(dur);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kh_flash_wr_chk.sv
module kh_flash_wr_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_start,
    input logic              fl_prog,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              busy,
    input logic              kh_closed,
    input logic              st_cmp,
    input logic              irq,
    input logic              ien,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [ADDR_W-1:0] kaddr
);

    AST_START_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |=> fl_prog); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> $stable(fl_addr)); // R3

    AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> busy); // R5

    AST_CLOSED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        kh_closed |-> busy); // R6

    AST_LOCK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (kh_closed && reg_we && reg_addr == 3'd0) |=> $stable(kaddr)); // R6

    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cmp && !(reg_we && reg_addr == 3'd4 && reg_wdata[2])) |=> st_cmp); // R7

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien); // R8

endmodule

bind kh_flash_wr kh_flash_wr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fl_start(fl_start), .fl_prog(fl_prog), .fl_addr(fl_addr),
    .busy(busy), .kh_closed(kh_closed), .st_cmp(st_cmp), .irq(irq), .ien(ien),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .kaddr(kaddr)
);

// File: tb/kh_flash_wr_tb.sv
module kh_flash_wr_tb;

    localparam int ALM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_done = 1'b1;
    logic        fl_start, fl_cont, fl_prog, irq;
    logic [15:0] fl_addr;
    logic [63:0] fl_data;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    kh_flash_wr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_done(fl_done),
        .fl_start(fl_start), .fl_cont(fl_cont), .fl_prog(fl_prog),
        .fl_addr(fl_addr), .fl_data(fl_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called on a falling edge; returns on the falling edge after the write edge
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int durs[9] = '{0, 1, 2, 3, 4, 5, 7, 8, 16};
        int starts;
        int seen_t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", 64'(v), (a == 6) ? 64'd16 : 64'd0);
        end
        check("R1 outs", {61'd0, fl_start, fl_prog, irq}, 64'd0);

        // R2 address trimming
        @(negedge clk);
        reg_write(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v);
        check("R2 trim", 64'(v), 64'h7FFF8);
        reg_write(3'd0, 32'h0000_0107);
        rd(3'd0, v);
        check("R2 align", 64'(v), 64'h100);

        // R3 R5 R6 R7 R8 sweep over durations
        for (int di = 0; di < 9; di++) begin
            int L;
            logic [31:0] lo, hi, ad;
            logic e_busy, e_cl, e_cmp, e_alm;
            L  = (durs[di] == 0) ? 1 : durs[di];
            lo = 32'h1111_0000 + 32'(di);
            hi = 32'hA5A5_0000 ^ 32'(di * 7);
            ad = 32'(di * 37 + 5) << 3;
            @(negedge clk);
            reg_write(3'd6, 32'(durs[di]));
            reg_write(3'd5, 32'(di % 2));
            reg_write(3'd0, ad);
            reg_write(3'd1, lo);
            reg_write(3'd2, hi);
            reg_write(3'd4, 32'h1C);
            reg_write(3'd3, 32'h4);
            for (int t = 0; t <= L + 3; t++) begin
                e_busy = (t <= L + 1);
                e_cl   = (t == 0) || (t >= 1 && t <= L && (L - t + 1) > (L / 2));
                e_cmp  = (t >= L + 2);
                e_alm  = (L >= ALM) && (t >= L - ALM + 2);
                rd(3'd4, v);
                check("R5 busy", 64'(v[0]), 64'(e_busy));
                check("R6 closed", 64'(v[1]), 64'(e_cl));
                check("R7 complete", 64'(v[2]), 64'(e_cmp));
                check("R8 almost", 64'(v[3]), 64'(e_alm));
                check("R8 irq", 64'(irq), 64'(e_alm && (di % 2 == 1)));
                check("R3 start", 64'(fl_start), 64'(t == 0));
                check("R3 prog", 64'(fl_prog), 64'(t >= 1 && t <= L));
                if (t == 0) begin
                    check("R3 data", fl_data, {hi, lo});
                    check("R2 word index", 64'(fl_addr), 64'(ad >> 3));
                    check("R9 first full", 64'(fl_cont), 64'd0);
                end
                @(negedge clk);
            end
        end

        // R8 R7 write-1-to-clear
        reg_write(3'd4, 32'h0C);
        rd(3'd4, v);
        check("R7 R8 clear", 64'(v[4:0]), 64'd0);

        // R4 unknown code
        reg_write(3'd3, 32'h5);
        rd(3'd4, v);
        check("R4 no start", 64'(v[0]), 64'd0);
        check("R4 err set", 64'(v[4]), 64'd1);
        @(negedge clk);
        reg_write(3'd4, 32'h10);
        rd(3'd4, v);
        check("R4 err clear", 64'(v[4]), 64'd0);

        // R6 lock while closed, then open window accepts
        @(negedge clk);
        reg_write(3'd6, 32'd16);
        reg_write(3'd0, 32'h200);
        reg_write(3'd3, 32'h4);
        reg_write(3'd0, 32'h7F8);       // edge t=1, closed
        reg_write(3'd1, 32'hDEAD);      // edge t=2, closed
        rd(3'd0, v);
        check("R6 addr locked", 64'(v), 64'h200);
        rd(3'd1, v);
        check("R6 data locked", 64'(v), 64'h1111_0008);
        for (int t = 2; t < 10; t++) @(negedge clk);
        reg_write(3'd0, 32'h7F8);       // t=10, open
        rd(3'd0, v);
        check("R6 open accepts", 64'(v), 64'h7F8);
        for (int t = 10; t < 20; t++) @(negedge clk);

        // R9 same-row queued write
        foreach (durs[k]) begin end
        for (int pass = 0; pass < 2; pass++) begin
            logic [31:0] a2;
            int L2;
            a2 = (pass == 0) ? (32'h41 << 3) : (32'h60 << 3);
            L2 = (pass == 0) ? 8 : 16;
            reg_write(3'd4, 32'h1C);
            reg_write(3'd0, 32'h40 << 3);
            reg_write(3'd3, 32'h4);     // t=0
            for (int t = 0; t < 9; t++) @(negedge clk);
            reg_write(3'd0, a2);        // edge 10
            reg_write(3'd1, 32'h0BAD_0000 + 32'(pass));
            reg_write(3'd2, 32'h7777_7777);
            reg_write(3'd3, 32'h4);     // edge 13, now t=13
            seen_t = -1;
            for (int t = 13; t <= 40; t++) begin
                if (fl_start && seen_t < 0) begin
                    seen_t = t;
                    check("R9 cont flag", 64'(fl_cont), 64'(pass == 0));
                    check("R9 queued addr", 64'(fl_addr), 64'(a2 >> 3));
                    check("R9 queued data", fl_data, {32'h7777_7777, 32'h0BAD_0000 + 32'(pass)});
                end
                rd(3'd4, v);
                if (t == 18 + L2 + 1) check("R9 busy before end", 64'(v[0]), 64'd1);
                if (t == 18 + L2 + 2) check("R9 busy end", 64'(v[0]), 64'd0);
                @(negedge clk);
            end
            check("R9 relaunch cycle", 64'(seen_t), 64'd18);
        end

        // R10 second queued command dropped
        reg_write(3'd6, 32'd8);
        reg_write(3'd4, 32'h1C);
        reg_write(3'd3, 32'h4);         // t=0
        reg_write(3'd3, 32'h4);         // queued
        reg_write(3'd3, 32'h4);         // dropped, now t=2
        starts = 0;
        for (int t = 2; t <= 20; t++) begin
            if (fl_start) starts++;
            rd(3'd4, v);
            if (t == 15) check("R10 busy", 64'(v[0]), 64'd1);
            if (t == 16) check("R10 idle", 64'(v[0]), 64'd0);
            @(negedge clk);
        end
        check("R10 launches", 64'(starts), 64'd1);
        rd(3'd4, v);
        check("R10 err", 64'(v[4]), 64'd1);

        // R11 done held low
        reg_write(3'd4, 32'h1C);
        reg_write(3'd6, 32'd4);
        fl_done = 1'b0;
        reg_write(3'd3, 32'h4);         // t=0
        for (int t = 0; t < 15; t++) @(negedge clk);
        rd(3'd4, v);
        check("R11 stall busy", 64'(v[0]), 64'd1);
        check("R11 no complete", 64'(v[2]), 64'd0);
        fl_done = 1'b1;
        @(negedge clk);
        rd(3'd4, v);
        check("R11 release", 64'(v[2:0]), 64'b100);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule